// File: doc/BRIEF.md
# Lockstep LFSR Bank with Divergence Flag

This block runs sixteen copies of the same 16-bit pseudo-random generator side by side, on one clock and one reset. Each copy is a Fibonacci-form linear feedback shift register with a maximal-length polynomial, seeded with a nonzero value. Because the copies start from the same seed and step together, a healthy block keeps all sixteen states identical forever. A registered comparator watches the full state of every copy and raises a single flag while all of them agree.

A particle strike or other disturbance that flips one stored bit in one copy makes that copy diverge. Each step function is a bijection, so two states that differ keep differing, and the flag stays low until the next reset. A test input flips a chosen bit of a chosen copy on a clock edge, which emulates such an upset. The serial output of one copy, fixed by a parameter, is brought out for direct observation of the bit stream.

The external reset is asserted asynchronously, and its release is retimed through a two-stage synchronizer before it reaches the registers.

Top module: `lfsr_upset_monitor`

## Requirements
- R1: Every copy advances once per clock edge while running. The new state is the old state shifted one place toward the MSB. Bit 0 receives the XOR of old bits 15, 13, 12 and 10, which is the polynomial x^16+x^14+x^13+x^11+1.
- R2: While `rst_n` is low, every copy holds the seed 16'h0001, `eq_flag` is 1 and `ser_out` is 0. This takes effect at once, without waiting for a clock edge.
- R3: After `rst_n` rises, the first two rising edges do not advance the copies and ignore any flip request. The first step happens on the third rising edge.
- R4: `ser_out` equals bit 15 of the state of copy `OBS_IDX`, which defaults to copy 0. A flip applied to that copy shows up in the stream.
- R5: `eq_flag` is registered. After each edge it is 1 exactly when all sixteen full states were equal just before that edge. Equal copies never produce a false alarm.
- R6: When `inj_en` is high at a running edge, copy `inj_copy` takes its normal next state with bit `inj_bit` inverted. If the copies were equal, `eq_flag` goes low after the following edge.
- R7: After a divergence, and with no further flip requests, `eq_flag` stays low until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all copies and the comparator |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchronizer |
| inj_en | input | 1 | Request to flip one stored bit on this edge |
| inj_copy | input | 4 | Index of the copy to disturb |
| inj_bit | input | 4 | Bit position to invert in that copy |
| ser_out | output | 1 | MSB of the observed copy |
| eq_flag | output | 1 | Registered all-copies-equal indication |

## Verification
A healthy bank never diverges, so the interesting states can only be reached through the flip input. Those states are a divergence, its persistence, and a second flip in the same copy that exactly cancels the first. The reset-release window is the hardest part. Flips placed on the first two edges after release must leave no trace. A flip on the third edge must be caught two edges later. Directed sequences time the flip input against those exact edges. Seeded random epochs scatter flips over copies and bits, and a bench model of all sixteen states predicts the flag and the stream.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  localparam int unsigned LFSR_W_DEF = 16;
  localparam int unsigned LFSR_N_DEF = 16;
  localparam logic [15:0] LFSR_TAPS_DEF = 16'hB400;
  localparam logic [15:0] LFSR_SEED_DEF = 16'h0001;
endpackage

// File: rtl/lfsr_rst_release.sv
module lfsr_rst_release #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign run_n = sync_q[STAGES-1];
endmodule

// File: rtl/lfsr_cell.sv
module lfsr_cell #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'h0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inj_hit,
  input  logic [W-1:0] inj_mask,
  output logic [W-1:0] state
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         fb;

  always_comb begin
    fb      = ^(state_q & TAPS);
    state_d = {state_q[W-2:0], fb} ^ (inj_hit ? inj_mask : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R1: undisturbed steps move every bit one place toward the MSB
  assert_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_hit |=> state_q[W-1:1] == $past(state_q[W-2:0]));
endmodule

// File: rtl/lfsr_eq_cmp.sv
module lfsr_eq_cmp #(
  parameter int unsigned NUM = 16,
  parameter int unsigned W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM*W-1:0] states_flat,
  output logic             eq_q
);
  logic [NUM-1:0] match;
  logic           eq_d;

  for (genvar i = 0; i < NUM; i++) begin : g_match
    assign match[i] = (states_flat[i*W +: W] == states_flat[0 +: W]);
  end

  always_comb begin
    eq_d = &match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b1;
    else        eq_q <= eq_d;
  end
endmodule

// File: rtl/lfsr_upset_monitor.sv
module lfsr_upset_monitor
  import lfsr_pkg::*;
#(
  parameter int unsigned NUM     = LFSR_N_DEF,
  parameter int unsigned W       = LFSR_W_DEF,
  parameter logic [W-1:0] TAPS   = LFSR_TAPS_DEF,
  parameter logic [W-1:0] SEED   = LFSR_SEED_DEF,
  parameter int unsigned OBS_IDX = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inj_en,
  input  logic [$clog2(NUM)-1:0] inj_copy,
  input  logic [$clog2(W)-1:0]   inj_bit,
  output logic                   ser_out,
  output logic                   eq_flag
);
  localparam int unsigned IDX_W = $clog2(NUM);
  localparam int unsigned FLAT_W = NUM * W;

  logic              run_n;
  logic [W-1:0]      inj_mask;
  logic [NUM-1:0]    inj_hit;
  logic [FLAT_W-1:0] states_flat;

  lfsr_rst_release #(.STAGES(2)) u_release (
    .clk   (clk),
    .rst_n (rst_n),
    .run_n (run_n)
  );

  always_comb begin
    inj_mask = '0;
    inj_mask[inj_bit] = 1'b1;
  end

  for (genvar i = 0; i < NUM; i++) begin : g_copy
    assign inj_hit[i] = inj_en && (inj_copy == IDX_W'(i));
    lfsr_cell #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_cell (
      .clk      (clk),
      .rst_n    (run_n),
      .inj_hit  (inj_hit[i]),
      .inj_mask (inj_mask),
      .state    (states_flat[i*W +: W])
    );
  end

  lfsr_eq_cmp #(.NUM(NUM), .W(W)) u_cmp (
    .clk         (clk),
    .rst_n       (run_n),
    .states_flat (states_flat),
    .eq_q        (eq_flag)
  );

  assign ser_out = states_flat[OBS_IDX*W + W - 1];

  // R5: matching copies with no recent flip keep the flag high
  assert_no_false_alarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_flag && !inj_en && !$past(inj_en)) |=> eq_flag);

  // R6: a flip into an agreeing bank is reported two edges later
  assert_detect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_flag && run_n && inj_en && !$past(inj_en) && (int'(inj_copy) < NUM))
      |=> ##1 !eq_flag);

  // R7: without a fresh flip, a mismatch persists
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!eq_flag && !$past(inj_en)) |=> !eq_flag);
endmodule

// File: tb/lfsr_upset_monitor_bench.sv
`timescale 1ns/1ps
module lfsr_upset_monitor_bench;
  localparam int NUM = 16;
  localparam int W = 16;
  localparam int OBS = 0;
  localparam logic [W-1:0] SEED = 16'h0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inj_en = 1'b0;
  logic [3:0] inj_copy = '0;
  logic [3:0] inj_bit = '0;
  logic ser_out;
  logic eq_flag;

  int n_chk = 0;
  int n_err = 0;
  bit auto_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lfsr_upset_monitor u_lfsr_upset_monitor (
    .clk(clk), .rst_n(rst_n), .inj_en(inj_en), .inj_copy(inj_copy),
    .inj_bit(inj_bit), .ser_out(ser_out), .eq_flag(eq_flag)
  );

  // bench model built from the requirements
  logic [W-1:0] m [NUM];
  logic m_r1, m_r2, exp_eq;

  function automatic logic [W-1:0] step_of(input logic [W-1:0] s);
    return {s[W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic model_same();
    logic r = 1'b1;
    for (int i = 1; i < NUM; i++) if (m[i] != m[0]) r = 1'b0;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 <= 1'b0; m_r2 <= 1'b0; exp_eq <= 1'b1;
      for (int i = 0; i < NUM; i++) m[i] <= SEED;
    end else begin
      m_r1 <= 1'b1;
      m_r2 <= m_r1;
      exp_eq <= model_same();
      if (m_r2)
        for (int i = 0; i < NUM; i++)
          m[i] <= step_of(m[i]) ^ ((inj_en && int'(inj_copy) == i) ? (W'(1) << inj_bit) : W'(0));
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (auto_on) begin
    chk("R1 R4 ser_out stream", ser_out, m[OBS][15]);
    chk("R5 eq_flag tracking", eq_flag, exp_eq);
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; inj_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 reset eq_flag", eq_flag, 1'b1);
    chk("R2 reset ser_out", ser_out, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic flip(input int c, input int b);
    inj_en = 1'b1; inj_copy = 4'(c); inj_bit = 4'(b);
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    do_reset();
    auto_on = 1'b1;

    // R3: flips on the first two edges after release are ignored
    do_reset();
    inj_en = 1'b1; inj_copy = 4'd0; inj_bit = 4'd15;
    @(negedge clk); @(negedge clk);
    inj_en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R3 flips before first step ignored", eq_flag, 1'b1);

    // R6: a flip on the third edge is seen after the fourth
    do_reset();
    @(negedge clk); @(negedge clk);
    flip(9, 0);
    chk("R6 flag before latency", eq_flag, 1'b1);
    @(negedge clk);
    chk("R6 flag after latency", eq_flag, 1'b0);

    // R7: mismatch persists
    repeat (500) @(negedge clk);
    chk("R7 flag stays low", eq_flag, 1'b0);

    // R5: no false alarm over a long clean run
    do_reset();
    repeat (1000) @(negedge clk);
    chk("R5 clean run flag high", eq_flag, 1'b1);

    // R4: flip in observed copy alters stream vs an untouched copy
    flip(OBS, 14);
    chk("R4 observed copy unchanged msb yet", ser_out, m[1][15]);
    @(negedge clk);
    chk("R4 observed copy stream flipped", ser_out, ~m[1][15]);

    // R6 cancellation: second flip in the same copy restores agreement
    do_reset();
    repeat (40) @(negedge clk);
    inj_en = 1'b1; inj_copy = 4'd3; inj_bit = 4'd2;
    @(negedge clk);
    inj_bit = 4'd3;
    @(negedge clk);
    inj_en = 1'b0;
    chk("R6 diverged copy flagged", eq_flag, 1'b0);
    @(negedge clk);
    chk("R5 cancelled flip restores flag", eq_flag, 1'b1);

    // seeded random epochs
    for (int e = 0; e < 8; e++) begin
      int len = 500 + int'($urandom_range(2000));
      do_reset();
      for (int k = 0; k < len; k++) begin
        if ($urandom_range(399) == 0) begin
          inj_en = 1'b1;
          inj_copy = 4'($urandom_range(15));
          inj_bit = 4'($urandom_range(15));
        end else begin
          inj_en = 1'b0;
        end
        @(negedge clk);
      end
      inj_en = 1'b0;
    end

    @(negedge clk);
    auto_on = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule